// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-mapped controller that runs Clause 22 management frames on an MDC clock line and a bidirectional MDIO data line. A host writes a 32-bit command word that holds a launch flag, the frame type, the opcode, a PHY address, a register address and the data to send. The block then drives the whole frame itself. A second 32-bit register carries the settings for the management clock and for read sampling, and it also returns the idle flag and the last read result.

Each frame starts with a run of ones as preamble. After that come the start pattern, the opcode, both addresses MSB first, a two-bit turnaround and sixteen data bits. On a read the block stops driving the data pin at the turnaround and shifts in the sixteen bits that the PHY returns. Sampling uses an MDC edge chosen by software, followed by a programmable delay counted in system clocks. The launch flag clears when the frame is over. The host can detect completion by polling either that flag or the idle flag.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is 0, the output enable is 0, the command register reads 0x00000000 and the status register reads 0x00010000 (idle set, everything else zero).
- R2: A legal command written to byte offset 0x0 with bit 31 set starts a frame. From the next cycle, command bit 31 reads 1 and status bit 16 reads 0. Once the frame is complete, bit 31 reads 0 and bit 16 reads 1.
- R3: During a frame, MDC stays at each level for T+1 system clocks, where T is status bits 31:24 and a T of 0 counts as 1. MDC stays 0 while the block is idle.
- R4: For a write (command bits 27:26 = 01), the data pin carries 64 bits, each stable at its MDC rising edge. They are 32 ones, then 01, then 01, then command bits 25:21, then bits 20:16, then 10, then bits 15:0, every field MSB first. The output enable is 1 for all 64 bits.
- R5: For a read (opcode 10), the first 46 bits follow the same pattern with opcode 10. The output enable is 0 for the last 18 bit times (turnaround and data).
- R6: On a read, the 16 data bits are shifted in MSB first and appear on status bits 15:0 once the frame completes. Status bit 23 = 0 samples at the MDC rising edge and bit 23 = 1 at the falling edge. In both cases sampling happens L system clocks after that edge, where L is status bits 22:20.
- R7: A command write that arrives while a frame is running has no effect. The frame on the pins, the command fields read back on bits 28:0, and the read result all stay those of the running frame.
- R8: A command with bit 28 = 0, or with opcode 00 or 11, does not start a frame. The block stays idle, command bit 31 reads 0 and MDC does not toggle.
- R9: A write frame leaves status bits 15:0 unchanged.
- R10: Status bits 31:24, 23 and 22:20 read back the values last written to them at byte offset 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Byte offset of the register (0x0 command, 0x4 status) |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data pin output value |
| mdioOe | output | 1 | Data pin output enable |
| mdioIn | input | 1 | Data pin input value |

## Verification
Two things can land on the same system clock. The first is falling-edge sampling with zero delay, where a data bit is captured on the very cycle the bit counter advances. The second is the end of a read frame, where the final capture falls on the same edge that ends the frame or is still pending inside its delay window. Random transactions combine edge choice, latch delay and MDC threshold, with one directed read at the largest threshold. A bench PHY model changes its output a fixed time after each MDC fall. The recovered word is compared with what the model sent, so a capture taken on the wrong cycle or lost at the end of the frame shows up as a wrong value. In a separate case a second command is written in the middle of a frame. The bench then checks that the frame bits, the command read-back and the result all still belong to the first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W = 32;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam int FIRE_BIT = 31;
  localparam int TYPE_BIT = 28;
  localparam int IDLE_BIT = 16;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} ctlState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
    logic finish;
  } ctlStrobe_t;
endpackage

// File: rtl/mdio_ctl.sv
module mdio_ctl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W = 8,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [REG_W-1:0] cmdWord,
  input  logic [DIV_W-1:0] thr,
  input  logic             edgeSel,
  input  logic [LAT_W-1:0] latch,
  output ctlStrobe_t       strb,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] TA_START = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(PRE_LEN + 16);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);

  ctlState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [LAT_W-1:0] dly;
  logic mdcQ, isRead, pend;

  logic [DIV_W-1:0] thrEff;
  logic [1:0] cmdOp;
  logic accept, tick, fallTick, edgeHit;

  assign cmdOp = cmdWord[27:26];
  assign thrEff = (thr == '0) ? DIV_W'(1) : thr;
  assign accept = cmdWr && (state == S_IDLE) && cmdWord[FIRE_BIT] && cmdWord[TYPE_BIT]
                  && ((cmdOp == OP_WRITE) || (cmdOp == OP_READ));
  assign tick = (state == S_RUN) && (divCnt >= thrEff);
  assign fallTick = tick && mdcQ;
  assign edgeHit = tick && (mdcQ == edgeSel) && isRead && (bitCnt >= DATA_START);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      mdcQ <= 1'b0;
      isRead <= 1'b0;
      pend <= 1'b0;
      dly <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_RUN;
          divCnt <= '0;
          bitCnt <= '0;
          mdcQ <= 1'b0;
          isRead <= (cmdOp == OP_READ);
        end
        S_RUN: begin
          if (tick) begin
            divCnt <= '0;
            mdcQ <= ~mdcQ;
            if (mdcQ) begin
              if (bitCnt == LAST_BIT) state <= S_DRAIN;
              else bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        S_DRAIN: if (!pend) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (edgeHit && (latch != '0)) begin
        pend <= 1'b1;
        dly <= latch - 1'b1;
      end else if (pend) begin
        if (dly == '0) pend <= 1'b0;
        else dly <= dly - 1'b1;
      end
    end
  end

  always_comb begin
    strb.load = accept;
    strb.shift = fallTick && (bitCnt != LAST_BIT);
    strb.capture = (edgeHit && (latch == '0)) || (pend && (dly == '0));
    strb.finish = (state == S_DRAIN) && !pend;
  end

  assign busy = (state != S_IDLE);
  assign mdc = mdcQ;
  assign mdioOe = (state == S_RUN) && !(isRead && (bitCnt >= TA_START));

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

  // R5
  capture_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !mdioOe);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W = 8,
  parameter int LAT_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  ctlStrobe_t        strb,
  input  logic              busy,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              cmdWr,
  output logic [DIV_W-1:0]  thr,
  output logic              edgeSel,
  output logic [LAT_W-1:0]  latch
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4);

  logic [28:0] cmdReg;
  logic [FRAME_LEN-1:0] txShift;
  logic [15:0] rxShift, rdHold;
  logic cfgWr;

  assign cmdWr = regWr && (regAddr == CMD_OFS);
  assign cfgWr = regWr && (regAddr == STAT_OFS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      txShift <= '1;
      rxShift <= '0;
      rdHold <= '0;
      thr <= '0;
      edgeSel <= 1'b0;
      latch <= '0;
    end else begin
      if (cfgWr) begin
        thr <= regWdata[31 -: DIV_W];
        edgeSel <= regWdata[23];
        latch <= regWdata[20 +: LAT_W];
      end
      if (strb.load) begin
        cmdReg <= regWdata[28:0];
        txShift <= {{PRE_LEN{1'b1}}, 2'b01, regWdata[27:16], 2'b10, regWdata[15:0]};
      end else if (strb.shift) begin
        txShift <= {txShift[FRAME_LEN-2:0], 1'b1};
      end
      if (strb.capture) rxShift <= {rxShift[14:0], mdioIn};
      if (strb.finish && (cmdReg[27:26] == OP_READ)) rdHold <= rxShift;
    end
  end

  assign mdioOut = busy ? txShift[FRAME_LEN-1] : 1'b1;

  always_comb begin
    regRdata = '0;
    if (regAddr == CMD_OFS) begin
      regRdata = {busy, 2'b00, cmdReg};
    end else if (regAddr == STAT_OFS) begin
      regRdata[31 -: DIV_W] = thr;
      regRdata[23] = edgeSel;
      regRdata[20 +: LAT_W] = latch;
      regRdata[IDLE_BIT] = !busy;
      regRdata[15:0] = rdHold;
    end
  end

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdReg));

  // R8
  load_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (cmdWr && regWdata[FIRE_BIT] && regWdata[TYPE_BIT]));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.finish}));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && (cmdReg[27:26] == OP_WRITE)) |=> $stable(rdHold));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W = 8,
  parameter int LAT_W = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  ctlStrobe_t strb;
  logic busy, cmdWr, edgeSel;
  logic [DIV_W-1:0] thr;
  logic [LAT_W-1:0] latch;

  mdio_ctl #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W), .LAT_W(LAT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWord(regWdata),
    .thr(thr), .edgeSel(edgeSel), .latch(latch),
    .strb(strb), .busy(busy), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dp #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W), .LAT_W(LAT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .busy(busy),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .cmdWr(cmdWr),
    .thr(thr), .edgeSel(edgeSel), .latch(latch)
  );
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int monCnt = 0;
  int fallCnt = 0;
  logic monOut [0:127];
  logic monOe [0:127];
  int monCyc [0:127];
  logic [15:0] phyReply = '0;
  logic [15:0] lastRead = '0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    if (monCnt < 128) begin
      monOut[monCnt] = mdioOut;
      monOe[monCnt] = mdioOe;
      monCyc[monCnt] = cyc;
    end
    monCnt = monCnt + 1;
  end

  // bench PHY: output changes 1.5 clocks after each MDC fall
  always @(negedge mdc) begin
    logic v;
    fallCnt = fallCnt + 1;
    if (fallCnt == 47) v = 1'b0;
    else if (fallCnt >= 48 && fallCnt <= 63) v = phyReply[63 - fallCnt];
    else v = 1'b1;
    #6;
    mdioIn = v;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [63:0] buildFrame(input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wd};
  endfunction

  function automatic int thrEff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic doTxn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] reply, input int thr,
                       input logic edgeS, input int lat, input logic midCmd);
    logic [31:0] r;
    logic [63:0] exp;
    logic [31:0] cmd;
    bit frameOk, oeOk, perOk;
    int half, waitCnt;
    regWrite(3'd4, {thr[7:0], edgeS, lat[2:0], 20'h0});
    regRead(3'd4, r);
    check("R10 config readback", r & 32'hFFF0_0000, {thr[7:0], edgeS, lat[2:0], 20'h0});
    phyReply = reply;
    fallCnt = 0;
    monCnt = 0;
    cmd = {1'b1, 2'b00, 1'b1, op, phy, rg, wd};
    regWrite(3'd0, cmd);
    regRead(3'd4, r);
    check("R2 idle clears on accept", {31'h0, r[16]}, 32'h0);
    regRead(3'd0, r);
    check("R2 fire reads 1 while busy", {31'h0, r[31]}, 32'h1);
    waitCnt = 0;
    do begin
      @(negedge clk);
      waitCnt++;
      if (midCmd && waitCnt == 100)
        regWrite(3'd0, {1'b1, 2'b00, 1'b1, ~op, ~phy, ~rg, ~wd});
      regRead(3'd4, r);
    end while (r[16] == 1'b0 && waitCnt < 60000);
    check("R2 idle returns", {31'h0, r[16]}, 32'h1);
    if (op == 2'b10) lastRead = reply;
    check(op == 2'b10 ? "R6 read data" : "R9 write keeps read data", {16'h0, r[15:0]}, {16'h0, lastRead});
    regRead(3'd0, r);
    check("R2 fire clears at end", {31'h0, r[31]}, 32'h0);
    if (midCmd) check("R7 command fields kept", {3'b0, r[28:0]}, {3'b0, cmd[28:0]});
    check("R4 R5 bit count", monCnt, 64);
    exp = buildFrame(op, phy, rg, wd);
    frameOk = 1; oeOk = 1; perOk = 1;
    half = thrEff(thr) + 1;
    for (int i = 0; i < 64; i++) begin
      bit expOe = !(op == 2'b10 && i >= 46);
      if (monOe[i] !== expOe) oeOk = 0;
      if (expOe && monOut[i] !== exp[63 - i]) frameOk = 0;
      if (i > 0 && (monCyc[i] - monCyc[i-1]) != 2 * half) perOk = 0;
    end
    check(op == 2'b10 ? "R5 read header bits" : "R4 write frame bits", {31'h0, frameOk}, 32'h1);
    check(op == 2'b10 ? "R5 output enable" : "R4 output enable", {31'h0, oeOk}, 32'h1);
    check("R3 MDC period", {31'h0, perOk}, 32'h1);
    repeat (5) @(negedge clk);
    check("R3 MDC low when idle", {31'h0, mdc}, 32'h0);
  endtask

  task automatic badCmd(input logic [31:0] cmd, input string req);
    logic [31:0] r;
    monCnt = 0;
    regWrite(3'd0, cmd);
    regRead(3'd4, r);
    check(req, {31'h0, r[16]}, 32'h1);
    regRead(3'd0, r);
    check(req, {31'h0, r[31]}, 32'h0);
    repeat (40) @(negedge clk);
    check(req, monCnt, 0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    regRead(3'd0, r);
    check("R1 command reset", r, 32'h0);
    regRead(3'd4, r);
    check("R1 status reset", r, 32'h0001_0000);
    check("R1 mdc and oe reset", {30'h0, mdc, mdioOe}, 32'h0);

    // directed corner cases
    doTxn(2'b01, 5'h15, 5'h0A, 16'hA55A, 16'h0, 0, 1'b0, 0, 1'b0);
    doTxn(2'b10, 5'h01, 5'h1F, 16'h0, 16'hC3A5, 0, 1'b1, 0, 1'b0);
    doTxn(2'b10, 5'h1F, 5'h00, 16'h0, 16'h8001, 3, 1'b0, 3, 1'b0);
    doTxn(2'b10, 5'h0C, 5'h11, 16'h0, 16'h7E81, 4, 1'b1, 1, 1'b0);
    doTxn(2'b01, 5'h03, 5'h04, 16'hFFFF, 16'h0, 2, 1'b0, 0, 1'b0);
    doTxn(2'b10, 5'h12, 5'h05, 16'h0, 16'h1234, 5, 1'b0, 2, 1'b1);
    doTxn(2'b10, 5'h07, 5'h09, 16'h0, 16'hBEEF, 255, 1'b0, 7, 1'b0);
    badCmd(32'h8800_1234, "R8 clause-45 type ignored");
    badCmd(32'h9000_0000, "R8 opcode 00 ignored");
    badCmd(32'h9C00_0000, "R8 opcode 11 ignored");
    badCmd(32'h1800_0000, "R8 no fire bit");

    // random transactions
    for (int n = 0; n < 14; n++) begin
      int t, l;
      logic e;
      logic [1:0] op;
      t = $urandom % 6;
      e = 1'($urandom % 2);
      if (e) l = $urandom % 2;
      else l = $urandom % (thrEff(t) + 1);
      op = ($urandom % 2) ? 2'b10 : 2'b01;
      doTxn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), t, e, l, 1'($urandom % 4 == 0));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule